// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block holds the privileged control state of a small scalar core and decides when the core must leave its normal instruction stream. It keeps a status word, a cause word, a saved exception PC, a vector base, a captured fault address, and a retire-driven count/compare timer. The pipeline around it supplies a retire strobe, the PC of the instruction at hand, a synchronous trap request with its code and faulting address, an inter-processor interrupt pulse, and software writes to the status word, the compare value and the vector base.

In each cycle the unit checks whether an enabled interrupt is pending, whether a synchronous trap is requested, or whether a trap has arrived while traps are disabled. A taken trap produces a one-cycle redirect strobe with the vector base as the new PC, and it stacks the privilege bit. A trap that arrives while traps are disabled parks the core in a halted error state. Every change to the status word also produces a one-cycle TLB flush pulse. The current privilege, the translation enable and the effective register width are derived from the status word.

Top module: `trapctl_core`

## Requirements
- R1: After reset the status reads 0x000000A0 (supervisor with 64-bit supervisor width), and cause, EPC, bad address, redirect, flush, run and halted all read 0.
- R2: Status bit map: bit0 trap enable (ET), bit1 FPU enable, bit2 vector enable, bit3 compressed enable, bit4 previous supervisor (PS), bit5 supervisor (S), bit6 user 64-bit (UX), bit7 supervisor 64-bit (SX), bit8 VM enable, bits 23:16 interrupt mask. A status write stores only these bits; every other bit reads 0, and the enables of features that are configured off (by default FPU and vector) read 0.
- R3: A status write or a taken trap raises `tlb_flush_o` for exactly the next cycle. `supervisor_o` and `vm_en_o` follow status bits 5 and 8.
- R4: `xlen_o` is 64 when SX is set in supervisor mode or UX is set in user mode, and 32 otherwise.
- R5: A trap request while ET is set raises `redirect_o` for one cycle, starting in the cycle after the request. `redirect_pc_o` then shows the vector base, EPC holds the request's PC, and the bad-address register holds the request's fault address.
- R6: A taken trap clears ET, sets S, and copies the previous S into PS. A status write in the same cycle as a trap is dropped.
- R7: Cause map: bits 4:0 exception code, bits 23:16 interrupt pending. A trap writes its code into bits 4:0 and leaves the pending bits unchanged. Trap codes must be below NUM_TRAPS (20).
- R8: An interrupt trap with code 0 is taken when (pending AND mask) is non-zero and ET is set. It takes priority over a synchronous request in the same cycle.
- R9: Pending interrupts that are masked, or that arrive while ET is clear, cause no redirect and no halt.
- R10: A synchronous trap request while ET is clear sets `halted_o`, does not redirect, and leaves EPC unchanged. Once halted, no further trap is taken until reset.
- R11: The counter advances on each retire. A retire whose pre-increment count equals compare sets pending bit 7 (cause bit 23). A compare write clears that bit.
- R12: An inter-processor interrupt pulse sets pending bit 5 (cause bit 21) and raises `run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retires this cycle |
| pc_i | input | AW | PC of the current instruction |
| trap_req_i | input | 1 | Synchronous trap request |
| trap_code_i | input | CODE_W | Code of the requested trap |
| fault_addr_i | input | AW | Faulting address of the request |
| ipi_i | input | 1 | Inter-processor interrupt pulse |
| sr_wr_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 32 | Status write value |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write value |
| evec_wr_i | input | 1 | Vector base write strobe |
| evec_wdata_i | input | AW | Vector base write value |
| redirect_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | AW | Redirect target |
| supervisor_o | output | 1 | Supervisor mode |
| vm_en_o | output | 1 | Translation enabled |
| xlen_o | output | 7 | Effective register width (32 or 64) |
| tlb_flush_o | output | 1 | One-cycle TLB flush pulse |
| run_o | output | 1 | Run flag |
| halted_o | output | 1 | Halted error state |
| status_o | output | 32 | Status word |
| cause_o | output | 32 | Cause word |
| epc_o | output | AW | Saved exception PC |
| badvaddr_o | output | AW | Captured fault address |

## Verification
Every result of this unit is registered once. A status write, trap, IPI, compare write or retire therefore shows at the ports exactly one clock edge after the cycle in which it was driven. Derived outputs such as width, privilege and translation enable follow the registered status in that same cycle. The bench drives inputs just after a falling edge and holds them through one rising edge. It samples at the next falling edge, so each check looks at the first cycle the effect is due. Where the requirement says the effect is a single pulse, the bench also checks the cycle after. An enabled interrupt needs two edges, one to register the mask and one to take the trap, and the bench checks both cycles.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;

    localparam int SR_W    = 32;
    localparam int CAUSE_W = 32;

    // status bit positions
    localparam int SB_ET  = 0;
    localparam int SB_EF  = 1;
    localparam int SB_EV  = 2;
    localparam int SB_EC  = 3;
    localparam int SB_PS  = 4;
    localparam int SB_S   = 5;
    localparam int SB_UX  = 6;
    localparam int SB_SX  = 7;
    localparam int SB_VM  = 8;
    localparam int IM_LSB = 16;

    // cause layout
    localparam int IRQ_N  = 8;
    localparam int EXC_W  = 5;
    localparam int IP_LSB = 16;

    // bits that can ever hold a one
    function automatic logic [SR_W-1:0] sr_keep_mask(bit has64, bit hasfpu,
                                                      bit hasrvc, bit hasvec);
        logic [SR_W-1:0] m;
        m = '0;
        m[SB_ET] = 1'b1;
        m[SB_EF] = hasfpu;
        m[SB_EV] = hasvec;
        m[SB_EC] = hasrvc;
        m[SB_PS] = 1'b1;
        m[SB_S]  = 1'b1;
        m[SB_UX] = has64;
        m[SB_SX] = has64;
        m[SB_VM] = 1'b1;
        m[IM_LSB +: IRQ_N] = '1;
        return m;
    endfunction

endpackage

// File: rtl/trapctl_sr_clean.sv
module trapctl_sr_clean
    import trapctl_pkg::*;
#(
    parameter bit HAS_64  = 1'b1,
    parameter bit HAS_FPU = 1'b0,
    parameter bit HAS_RVC = 1'b1,
    parameter bit HAS_VEC = 1'b0
) (
    input  logic [SR_W-1:0] raw_i,
    output logic [SR_W-1:0] clean_o
);

    logic [SR_W-1:0] base;
    assign base = raw_i & sr_keep_mask(1'b1, 1'b1, 1'b1, 1'b1);

    logic [SR_W-1:0] strip;
    always_comb begin
        strip = '0;
        if (!HAS_64) begin
            strip[SB_UX] = 1'b1;
            strip[SB_SX] = 1'b1;
        end
        if (!HAS_FPU) strip[SB_EF] = 1'b1;
        if (!HAS_RVC) strip[SB_EC] = 1'b1;
        if (!HAS_VEC) strip[SB_EV] = 1'b1;
    end

    assign clean_o = base & ~strip;

endmodule

// File: rtl/trapctl_arb.sv
module trapctl_arb
    import trapctl_pkg::*;
(
    input  logic [IRQ_N-1:0] ip_i,
    input  logic [IRQ_N-1:0] im_i,
    input  logic             et_i,
    input  logic             halted_i,
    input  logic             sync_req_i,
    output logic             take_irq_o,
    output logic             take_sync_o,
    output logic             enter_halt_o
);

    logic irq_live;
    assign irq_live = |(ip_i & im_i);

    always_comb begin
        take_irq_o   = 1'b0;
        take_sync_o  = 1'b0;
        enter_halt_o = 1'b0;
        if (!halted_i) begin
            if (et_i) begin
                if (irq_live)        take_irq_o  = 1'b1;
                else if (sync_req_i) take_sync_o = 1'b1;
            end else if (sync_req_i) begin
                enter_halt_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/trapctl_timer.sv
module trapctl_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             retire_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] compare;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (retire_i) tm_d.count = tm_q.count + 1'b1;
        if (cmp_wr_i) tm_d.compare = cmp_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tm_q <= '0;
        else         tm_q <= tm_d;
    end

    assign hit_o = retire_i && (tm_q.count == tm_q.compare);

endmodule

// File: rtl/trapctl_core.sv
module trapctl_core
    import trapctl_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CNT_W     = 32,
    parameter int CODE_W    = EXC_W,
    parameter int NUM_TRAPS = 20,
    parameter int INT_CODE  = 0,
    parameter int TIMER_IRQ = 7,
    parameter int IPI_IRQ   = 5,
    parameter bit HAS_64    = 1'b1,
    parameter bit HAS_FPU   = 1'b0,
    parameter bit HAS_RVC   = 1'b1,
    parameter bit HAS_VEC   = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              retire_i,
    input  logic [AW-1:0]     pc_i,
    input  logic              trap_req_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [AW-1:0]     fault_addr_i,
    input  logic              ipi_i,
    input  logic              sr_wr_i,
    input  logic [SR_W-1:0]   sr_wdata_i,
    input  logic              cmp_wr_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    input  logic              evec_wr_i,
    input  logic [AW-1:0]     evec_wdata_i,
    output logic              redirect_o,
    output logic [AW-1:0]     redirect_pc_o,
    output logic              supervisor_o,
    output logic              vm_en_o,
    output logic [6:0]        xlen_o,
    output logic              tlb_flush_o,
    output logic              run_o,
    output logic              halted_o,
    output logic [SR_W-1:0]   status_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [AW-1:0]     epc_o,
    output logic [AW-1:0]     badvaddr_o
);

    localparam logic [SR_W-1:0] SR_RESET = (SR_W'(1) << SB_S) | (HAS_64 ? (SR_W'(1) << SB_SX) : '0);
    localparam logic [CODE_W-1:0] IRQ_CODE = CODE_W'(INT_CODE);

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [CODE_W-1:0] exc;
        logic [IRQ_N-1:0]  ip;
        logic [AW-1:0]     epc;
        logic [AW-1:0]     evec;
        logic [AW-1:0]     badva;
        logic [AW-1:0]     rpc;
        logic              redirect;
        logic              flush;
        logic              run;
        logic              halted;
    } core_st_t;

    core_st_t st_d, st_q;

    // status sanitizers: index 0 for software writes, index 1 for trap entry
    logic [SR_W-1:0] sr_raw   [2];
    logic [SR_W-1:0] sr_clean [2];

    assign sr_raw[0] = sr_wdata_i;
    always_comb begin
        sr_raw[1]        = st_q.sr;
        sr_raw[1][SB_ET] = 1'b0;
        sr_raw[1][SB_PS] = st_q.sr[SB_S];
        sr_raw[1][SB_S]  = 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_clean
        trapctl_sr_clean #(
            .HAS_64 (HAS_64),
            .HAS_FPU(HAS_FPU),
            .HAS_RVC(HAS_RVC),
            .HAS_VEC(HAS_VEC)
        ) u_clean (
            .raw_i  (sr_raw[g]),
            .clean_o(sr_clean[g])
        );
    end

    logic timer_hit;
    trapctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .retire_i   (retire_i),
        .cmp_wr_i   (cmp_wr_i),
        .cmp_wdata_i(cmp_wdata_i),
        .hit_o      (timer_hit)
    );

    logic take_irq, take_sync, enter_halt;
    trapctl_arb u_arb (
        .ip_i        (st_q.ip),
        .im_i        (st_q.sr[IM_LSB +: IRQ_N]),
        .et_i        (st_q.sr[SB_ET]),
        .halted_i    (st_q.halted),
        .sync_req_i  (trap_req_i),
        .take_irq_o  (take_irq),
        .take_sync_o (take_sync),
        .enter_halt_o(enter_halt)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.flush    = 1'b0;

        // pending interrupt bits
        if (cmp_wr_i)  st_d.ip[TIMER_IRQ] = 1'b0;
        if (timer_hit) st_d.ip[TIMER_IRQ] = 1'b1;
        if (ipi_i) begin
            st_d.ip[IPI_IRQ] = 1'b1;
            st_d.run         = 1'b1;
        end

        if (evec_wr_i) st_d.evec = evec_wdata_i;

        if (take_irq || take_sync) begin
            st_d.sr       = sr_clean[1];
            st_d.flush    = 1'b1;
            st_d.exc      = take_irq ? IRQ_CODE : trap_code_i;
            st_d.epc      = pc_i;
            st_d.badva    = fault_addr_i;
            st_d.rpc      = st_q.evec;
            st_d.redirect = 1'b1;
        end else if (sr_wr_i) begin
            st_d.sr    = sr_clean[0];
            st_d.flush = 1'b1;
        end

        if (enter_halt) st_d.halted = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= '0;
            st_q.sr <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    logic wide_mode;
    assign wide_mode = st_q.sr[SB_S] ? st_q.sr[SB_SX] : st_q.sr[SB_UX];

    always_comb begin
        cause_o = '0;
        cause_o[CODE_W-1:0]        = st_q.exc;
        cause_o[IP_LSB +: IRQ_N]   = st_q.ip;
    end

    assign redirect_o    = st_q.redirect;
    assign redirect_pc_o = st_q.rpc;
    assign supervisor_o  = st_q.sr[SB_S];
    assign vm_en_o       = st_q.sr[SB_VM];
    assign xlen_o        = wide_mode ? 7'd64 : 7'd32;
    assign tlb_flush_o   = st_q.flush;
    assign run_o         = st_q.run;
    assign halted_o      = st_q.halted;
    assign status_o      = st_q.sr;
    assign epc_o         = st_q.epc;
    assign badvaddr_o    = st_q.badva;

endmodule

// File: rtl/trapctl_core_chk.sv
module trapctl_core_chk
    import trapctl_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CODE_W    = EXC_W,
    parameter int NUM_TRAPS = 20,
    parameter int IPI_IRQ   = 5,
    parameter bit HAS_64    = 1'b1,
    parameter bit HAS_FPU   = 1'b0,
    parameter bit HAS_RVC   = 1'b1,
    parameter bit HAS_VEC   = 1'b0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [AW-1:0]      pc_i,
    input logic               trap_req_i,
    input logic [CODE_W-1:0]  trap_code_i,
    input logic               ipi_i,
    input logic               sr_wr_i,
    input logic               redirect_o,
    input logic               tlb_flush_o,
    input logic               run_o,
    input logic               halted_o,
    input logic [SR_W-1:0]    status_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [AW-1:0]      epc_o
);

    localparam logic [SR_W-1:0] KEEP = sr_keep_mask(HAS_64, HAS_FPU, HAS_RVC, HAS_VEC);

    a_r2_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~KEEP) == '0);

    a_r3_flush_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_flush_o |-> ($past(sr_wr_i) || redirect_o));

    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> !redirect_o);

    a_r5_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> epc_o == $past(pc_i));

    a_r6_enter_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> (!status_o[SB_ET] && status_o[SB_S]
                        && status_o[SB_PS] == $past(status_o[SB_S])));

    a_r7_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_i |-> int'(trap_code_i) < NUM_TRAPS);

    a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halted_o |-> !redirect_o);

    a_r12_ipi_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ipi_i) |-> (run_o && cause_o[IP_LSB + IPI_IRQ]));

endmodule

bind trapctl_core trapctl_core_chk #(
    .AW       (AW),
    .CODE_W   (CODE_W),
    .NUM_TRAPS(NUM_TRAPS),
    .IPI_IRQ  (IPI_IRQ),
    .HAS_64   (HAS_64),
    .HAS_FPU  (HAS_FPU),
    .HAS_RVC  (HAS_RVC),
    .HAS_VEC  (HAS_VEC)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_i       (pc_i),
    .trap_req_i (trap_req_i),
    .trap_code_i(trap_code_i),
    .ipi_i      (ipi_i),
    .sr_wr_i    (sr_wr_i),
    .redirect_o (redirect_o),
    .tlb_flush_o(tlb_flush_o),
    .run_o      (run_o),
    .halted_o   (halted_o),
    .status_o   (status_o),
    .cause_o    (cause_o),
    .epc_o      (epc_o)
);

// File: tb/trapctl_core_tb_top.sv
module trapctl_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic [31:0] pc = '0;
    logic        treq = 1'b0;
    logic [4:0]  tcode = '0;
    logic [31:0] faddr = '0;
    logic        ipi = 1'b0;
    logic        sr_wr = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic        cmp_wr = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic        ev_wr = 1'b0;
    logic [31:0] ev_wdata = '0;

    logic        redirect, sup, vm, flush, run, halted;
    logic [31:0] rpc, status, cause, epc, badva;
    logic [6:0]  xlen;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trapctl_core dut_i (
        .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .pc_i(pc),
        .trap_req_i(treq), .trap_code_i(tcode), .fault_addr_i(faddr),
        .ipi_i(ipi), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata),
        .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wdata),
        .evec_wr_i(ev_wr), .evec_wdata_i(ev_wdata),
        .redirect_o(redirect), .redirect_pc_o(rpc), .supervisor_o(sup),
        .vm_en_o(vm), .xlen_o(xlen), .tlb_flush_o(flush), .run_o(run),
        .halted_o(halted), .status_o(status), .cause_o(cause),
        .epc_o(epc), .badvaddr_o(badva)
    );

    // {write value, expected status, expect 64-bit width}
    localparam logic [64:0] SR_VEC [6] = '{
        {32'hFFFF_FFFF, 32'h00FF_01F9, 1'b1},
        {32'h0000_0020, 32'h0000_0020, 1'b0},
        {32'h0000_0040, 32'h0000_0040, 1'b1},
        {32'h0000_00A0, 32'h0000_00A0, 1'b1},
        {32'h0000_0006, 32'h0000_0000, 1'b0},
        {32'h1234_5678, 32'h0034_0078, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 status", status, 32'h0000_00A0);
        chk("R1 cause", cause, 32'h0);
        chk("R1 epc", epc, 32'h0);
        chk("R1 badva", badva, 32'h0);
        chk("R1 redirect/flush/run/halted", {28'h0, redirect, flush, run, halted}, 32'h0);
        chk("R4 reset width", 32'(xlen), 32'd64);

        // table of status writes: R2, R3, R4
        for (int i = 0; i < 6; i++) begin
            sr_wr = 1'b1;
            sr_wdata = SR_VEC[i][64:33];
            step();
            sr_wr = 1'b0;
            chk("R2 status sanitize", status, SR_VEC[i][32:1]);
            chk("R3 flush on write", 32'(flush), 32'd1);
            chk("R3 supervisor", 32'(sup), 32'(SR_VEC[i][1 + 5]));
            chk("R3 vm enable", 32'(vm), 32'(SR_VEC[i][1 + 8]));
            chk("R4 width", 32'(xlen), SR_VEC[i][0] ? 32'd64 : 32'd32);
        end
        step();
        chk("R3 flush single cycle", 32'(flush), 32'd0);

        do_reset();

        // vector base and enable traps, supervisor
        ev_wr = 1'b1; ev_wdata = 32'h0000_1000;
        step();
        ev_wr = 1'b0;
        sr_wr = 1'b1; sr_wdata = 32'h00FF_00A1;
        step();
        sr_wr = 1'b0;
        chk("R2 enable traps", status, 32'h00FF_00A1);

        // R5/R6/R7 synchronous trap from supervisor
        pc = 32'h200; faddr = 32'hDEAD; treq = 1'b1; tcode = 5'd3;
        step();
        treq = 1'b0;
        chk("R5 redirect", 32'(redirect), 32'd1);
        chk("R5 target", rpc, 32'h1000);
        chk("R5 epc", epc, 32'h200);
        chk("R5 badva", badva, 32'hDEAD);
        chk("R7 exc code", cause, 32'h0000_0003);
        chk("R6 status", status, 32'h00FF_00B0);
        chk("R3 flush on trap", 32'(flush), 32'd1);
        step();
        chk("R5 single pulse", 32'(redirect), 32'd0);

        // user mode with UX, then trap: PS must take S=0
        sr_wr = 1'b1; sr_wdata = 32'h00FF_0041;
        step();
        sr_wr = 1'b0;
        chk("R3 user mode", 32'(sup), 32'd0);
        chk("R4 user width", 32'(xlen), 32'd64);
        pc = 32'h300; treq = 1'b1; tcode = 5'd5;
        step();
        treq = 1'b0;
        chk("R6 status from user", status, 32'h00FF_0060);
        chk("R7 new code", cause, 32'h0000_0005);

        // R12 inter-processor interrupt while traps are disabled
        ipi = 1'b1;
        step();
        ipi = 1'b0;
        chk("R12 cause bit", cause, 32'h0020_0005);
        chk("R12 run", 32'(run), 32'd1);
        chk("R9 no redirect with ET clear", 32'(redirect), 32'd0);

        // R9 masked pending interrupt
        sr_wr = 1'b1; sr_wdata = 32'h00DF_00A1;
        step();
        sr_wr = 1'b0;
        chk("R9 masked", 32'(redirect), 32'd0);
        step();
        chk("R9 masked later", 32'(redirect), 32'd0);

        // R8 unmask: interrupt wins over a same-cycle synchronous request
        sr_wr = 1'b1; sr_wdata = 32'h00FF_00A1;
        step();
        sr_wr = 1'b0;
        chk("R8 not yet", 32'(redirect), 32'd0);
        pc = 32'h400; treq = 1'b1; tcode = 5'd7;
        step();
        treq = 1'b0;
        chk("R8 irq redirect", 32'(redirect), 32'd1);
        chk("R8 irq code, pending kept", cause, 32'h0020_0000);
        chk("R8 epc", epc, 32'h400);
        chk("R8 status", status, 32'h00FF_00B0);
        step();
        chk("R9 pending with ET clear", 32'(redirect), 32'd0);
        chk("R9 no halt", 32'(halted), 32'd0);

        // R11 timer
        cmp_wr = 1'b1; cmp_wdata = 32'd3;
        step();
        cmp_wr = 1'b0;
        retire = 1'b1;
        step(); step(); step();
        chk("R11 before match", cause, 32'h0020_0000);
        step();
        retire = 1'b0;
        chk("R11 match sets bit", cause, 32'h00A0_0000);
        cmp_wr = 1'b1; cmp_wdata = 32'd10;
        step();
        cmp_wr = 1'b0;
        chk("R11 compare write clears", cause, 32'h0020_0000);

        // R10 trap with ET clear
        pc = 32'h500; treq = 1'b1; tcode = 5'd2;
        step();
        chk("R10 halted", 32'(halted), 32'd1);
        chk("R10 no redirect", 32'(redirect), 32'd0);
        chk("R10 epc kept", epc, 32'h400);
        step();
        treq = 1'b0;
        chk("R10 still no redirect", 32'(redirect), 32'd0);
        sr_wr = 1'b1; sr_wdata = 32'h00FF_00A1;
        step();
        sr_wr = 1'b0;
        step();
        chk("R10 halted blocks interrupt", 32'(redirect), 32'd0);
        chk("R10 cause kept", cause, 32'h0020_0000);

        do_reset();
        chk("R1 halt cleared", 32'(halted), 32'd0);
        chk("R1 cause cleared", cause, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule